// File: doc/BRIEF.md
# Dual-Mode Display Identification Memory Controller

This block is the digital core of a 256-byte display identification memory that presents two bus personalities. After reset it works as a transmit-only source. On each rising edge of a dedicated stream clock it serially emits the contents of the lower half of the array (locations 00h to 7Fh), MSB first, by pulling the shared data line low for zero bits. Once the array is exhausted the stream starts again at 00h.

A falling edge on SCL while the block is streaming marks host interest. The block then stops driving the data line and waits for an I2C control byte. If it sees a control byte addressed to it, the block becomes a byte-addressed I2C-compatible slave with read and write access to all 256 locations. Writes are gathered in an 8-byte page buffer and applied at STOP. A modelled write time follows each commit. Location 7Fh doubles as the arming point for hardware write protection. If no control byte arrives, a run of stream-clock pulses with a quiet SCL line returns the block to streaming.

All pins are sampled on the system clock. The array is an internal register file that resets to a computed pattern.

Top module: `ddc_monid`

## Requirements
- R1: After reset the block is in transmit-only mode, location a of the array holds (a XOR 5Ah), and sda_oe is asserted exactly when bit 7 of location 00h is 0.
- R2: In transmit-only mode each rising edge of vclk advances the stream by one bit. Bits go out MSB first through locations 00h..7Fh and then wrap back to 00h. sda_oe is asserted exactly when the current bit is 0.
- R3: A falling edge of scl during transmit-only mode enters the transition mode. In that mode sda_oe is released, and vclk pulses do not drive the line.
- R4: A control byte whose upper seven bits are 1010000 is acknowledged with sda_oe asserted throughout the ninth scl clock, and the block then enters bidirectional mode. Any other control byte is not acknowledged.
- R5: In transition mode, 128 vclk rising edges with no scl edge in between return the block to transmit-only mode, with the stream restarting at bit 7 of location 00h. Any scl edge clears the count.
- R6: A write control byte followed by a word address sets the address pointer. A read control byte then returns bytes from that pointer, incrementing it after each byte and wrapping from FFh to 00h. A master NACK ends the read.
- R7: After the word address, 1 to 8 data bytes are gathered and written to the array only at the STOP condition.
- R8: Data bytes beyond the end of the 8-byte aligned page wrap to its first location, and a later byte overwrites an earlier byte at the same location.
- R9: For WR_CYCLES system clocks after a commit, the control byte is not acknowledged.
- R10: The wp pin blocks writes only once location 7Fh has been written since reset. A blocked write leaves the array unchanged, and writes with wp low still succeed.
- R11: Bidirectional mode persists until reset, and vclk pulses in it neither drive sda_oe nor change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vclk | input | 1 | Stream clock for transmit-only mode |
| scl | input | 1 | I2C serial clock |
| sda_in | input | 1 | Level of the shared data line |
| wp | input | 1 | Write-protect request, effective once armed |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
An error in the stream bit or byte pointer appears on sda_oe within one vclk pulse. A wrong mode appears as a missing or unexpected acknowledge in the ninth clock of the next control byte. An error in the fallback counter shows only at the 128th pulse, so the bench probes the pulses just before and at that count, around an scl edge. Page-buffer, wrap and write-protect faults stay hidden until a later read, so every write is followed by a readback of its whole page against a bench model of the array.

// File: rtl/ddc_monid_pkg.sv
package ddc_monid_pkg;

    localparam int MEM_AW  = 8;
    localparam int PAGE_AW = 3;

    typedef enum logic [1:0] {
        MODE_TXO   = 2'd0,
        MODE_TRANS = 2'd1,
        MODE_BIDIR = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        SL_IDLE  = 3'd0,
        SL_CTRL  = 3'd1,
        SL_WADDR = 3'd2,
        SL_WDATA = 3'd3,
        SL_RDATA = 3'd4
    } sl_state_e;

    localparam logic [6:0] DEV_ID = 7'b1010000;

    // Reset content of the identification array
    function automatic logic [7:0] init_byte(input int a);
        logic [7:0] v;
        v = a[7:0];
        return v ^ 8'h5A;
    endfunction

endpackage

// File: rtl/ddc_id_mem.sv
module ddc_id_mem
    import ddc_monid_pkg::*;
#(
    parameter int AW = MEM_AW,
    parameter int PW = PAGE_AW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [AW-1:0]               ra_addr,
    output logic [7:0]                  ra_data,
    input  logic [AW-1:0]               rb_addr,
    output logic [7:0]                  rb_data,
    input  logic                        cm_en,
    input  logic [AW-PW-1:0]            cm_page,
    input  logic [(1<<PW)-1:0]          cm_mask,
    input  logic [(1<<PW)-1:0][7:0]     cm_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PB    = 1 << PW;

    logic [7:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= init_byte(i);
        end else if (cm_en) begin
            for (int j = 0; j < PB; j++) begin
                if (cm_mask[j]) arr[{cm_page, j[PW-1:0]}] <= cm_data[j];
            end
        end
    end

    assign ra_data = arr[ra_addr];
    assign rb_data = arr[rb_addr];

endmodule

// File: rtl/ddc_txo_ser.sv
module ddc_txo_ser
    import ddc_monid_pkg::*;
#(
    parameter int AW = MEM_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          vclk_rise,
    input  logic [7:0]    byte_in,
    output logic [AW-1:0] rd_addr,
    output logic          sda_low
);
    logic [AW-2:0] byte_ptr;
    logic [2:0]    bit_ptr;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            byte_ptr <= '0;
            bit_ptr  <= '0;
        end else if (vclk_rise) begin
            bit_ptr <= bit_ptr + 3'd1;
            if (bit_ptr == 3'd7) byte_ptr <= byte_ptr + 1'b1;
        end
    end

    assign rd_addr = {1'b0, byte_ptr};
    assign sda_low = active & ~byte_in[3'd7 - bit_ptr];

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !vclk_rise) |=> ($stable(byte_ptr) && $stable(bit_ptr)) || !active);

    // R5
    ptr_park_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (byte_ptr == '0 && bit_ptr == '0));

endmodule

// File: rtl/ddc_mode_arb.sv
module ddc_mode_arb
    import ddc_monid_pkg::*;
#(
    parameter int FALLBACK_PULSES = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_fall,
    input  logic  scl_edge,
    input  logic  vclk_rise,
    input  logic  ctrl_ok,
    output mode_e mode
);
    localparam int CW = $clog2(FALLBACK_PULSES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FALLBACK_PULSES);

    logic [CW-1:0] vcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_TXO;
            vcnt <= '0;
        end else begin
            unique case (mode)
                MODE_TXO: begin
                    vcnt <= '0;
                    if (scl_fall) mode <= MODE_TRANS;
                end
                MODE_TRANS: begin
                    if (ctrl_ok) begin
                        mode <= MODE_BIDIR;
                    end else if (vcnt == LIMIT) begin
                        mode <= MODE_TXO;
                        vcnt <= '0;
                    end else if (scl_edge) begin
                        vcnt <= '0;
                    end else if (vclk_rise) begin
                        vcnt <= vcnt + 1'b1;
                    end
                end
                default: mode <= MODE_BIDIR;
            endcase
        end
    end

    // R5
    fallback_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TXO && $past(mode) == MODE_TRANS) |-> $past(vcnt) == LIMIT);

    // R11
    bidir_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_BIDIR |=> mode == MODE_BIDIR);

    // R4
    no_skip_chk: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_TXO |=> mode != MODE_BIDIR);

endmodule

// File: rtl/ddc_i2c_slave.sv
module ddc_i2c_slave
    import ddc_monid_pkg::*;
#(
    parameter int             AW        = MEM_AW,
    parameter int             PW        = PAGE_AW,
    parameter int             WR_CYCLES = 400,
    parameter logic [AW-1:0]  ARM_ADDR  = AW'(8'h7F)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic                      sda,
    input  logic                      scl_rise,
    input  logic                      scl_fall,
    input  logic                      start_c,
    input  logic                      stop_c,
    input  logic                      wp,
    input  logic [7:0]                rd_data,
    output logic [AW-1:0]             rd_addr,
    output logic                      sda_low,
    output logic                      ctrl_ok,
    output logic                      cm_en,
    output logic [AW-PW-1:0]          cm_page,
    output logic [(1<<PW)-1:0]        cm_mask,
    output logic [(1<<PW)-1:0][7:0]   cm_data
);
    localparam int PB = 1 << PW;
    localparam int BW = $clog2(WR_CYCLES + 1);

    sl_state_e             st;
    logic [7:0]            shreg, rbyte;
    logic [3:0]            bitc;
    logic                  in_ack, nack, wp_armed;
    logic [AW-1:0]         ptr;
    logic [PB-1:0][7:0]    pbuf;
    logic [PB-1:0]         pmask;
    logic [BW-1:0]         busy_cnt;
    logic                  blocked;

    assign blocked = wp_armed & wp;
    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SL_IDLE;  shreg <= '0;  rbyte <= '0;  bitc <= '0;
            in_ack <= 1'b0; nack <= 1'b0; wp_armed <= 1'b0; ptr <= '0;
            pbuf <= '0;     pmask <= '0;  busy_cnt <= '0; sda_low <= 1'b0;
            ctrl_ok <= 1'b0; cm_en <= 1'b0; cm_page <= '0; cm_mask <= '0;
            cm_data <= '0;
        end else begin
            ctrl_ok <= 1'b0;
            cm_en   <= 1'b0;
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;

            if (!en) begin
                st <= SL_IDLE; sda_low <= 1'b0; in_ack <= 1'b0;
                bitc <= '0;    pmask <= '0;
            end else if (start_c) begin
                st <= SL_CTRL; sda_low <= 1'b0; in_ack <= 1'b0;
                bitc <= '0;    pmask <= '0;
            end else if (stop_c) begin
                st <= SL_IDLE; sda_low <= 1'b0; in_ack <= 1'b0; bitc <= '0;
                if (pmask != '0 && !blocked) begin
                    cm_en    <= 1'b1;
                    cm_page  <= ptr[AW-1:PW];
                    cm_mask  <= pmask;
                    cm_data  <= pbuf;
                    busy_cnt <= BW'(WR_CYCLES);
                    if (ptr[AW-1:PW] == ARM_ADDR[AW-1:PW] && pmask[ARM_ADDR[PW-1:0]])
                        wp_armed <= 1'b1;
                end
                pmask <= '0;
            end else if (st != SL_IDLE) begin
                if (scl_rise) begin
                    if (!in_ack) begin
                        shreg <= {shreg[6:0], sda};
                        bitc  <= bitc + 4'd1;
                    end else begin
                        nack <= sda;
                    end
                end else if (scl_fall) begin
                    if (!in_ack && bitc == 4'd8) begin
                        in_ack <= 1'b1;
                        unique case (st)
                            SL_CTRL: begin
                                if (shreg[7:1] == DEV_ID && busy_cnt == '0) begin
                                    sda_low <= 1'b1;
                                    ctrl_ok <= 1'b1;
                                    st      <= shreg[0] ? SL_RDATA : SL_WADDR;
                                end else begin
                                    st <= SL_IDLE;
                                end
                            end
                            SL_WADDR: begin
                                sda_low <= 1'b1;
                                ptr     <= shreg[AW-1:0];
                                st      <= SL_WDATA;
                            end
                            SL_WDATA: begin
                                sda_low <= 1'b1;
                                pbuf[ptr[PW-1:0]]  <= shreg;
                                pmask[ptr[PW-1:0]] <= 1'b1;
                                ptr[PW-1:0]        <= ptr[PW-1:0] + 1'b1;
                            end
                            default: begin
                                sda_low <= 1'b0;
                                ptr     <= ptr + 1'b1;
                            end
                        endcase
                    end else if (in_ack) begin
                        in_ack <= 1'b0;
                        bitc   <= '0;
                        if (st == SL_RDATA && !nack) begin
                            rbyte   <= rd_data;
                            sda_low <= ~rd_data[7];
                        end else begin
                            sda_low <= 1'b0;
                            if (st == SL_RDATA) st <= SL_IDLE;
                        end
                    end else if (st == SL_RDATA && bitc != 4'd0 && bitc < 4'd8) begin
                        sda_low <= ~rbyte[3'd7 - bitc[2:0]];
                    end
                end
            end
        end
    end

    // R10
    wp_block_chk: assert property (@(posedge clk) disable iff (rst)
        cm_en |-> !$past(wp_armed && wp));

    // R9
    busy_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_cnt != '0) |-> cm_en);

    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sda_low);

    // R7
    commit_mask_chk: assert property (@(posedge clk) disable iff (rst)
        cm_en |-> cm_mask != '0);

endmodule

// File: rtl/ddc_monid.sv
module ddc_monid
    import ddc_monid_pkg::*;
#(
    parameter int AW              = MEM_AW,
    parameter int PW              = PAGE_AW,
    parameter int FALLBACK_PULSES = 128,
    parameter int WR_CYCLES       = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic vclk,
    input  logic scl,
    input  logic sda_in,
    input  logic wp,
    output logic sda_oe
);
    localparam int PB = 1 << PW;

    logic vclk_q, scl_q, sda_q;
    logic vclk_rise, scl_fall, scl_rise, scl_edge, start_c, stop_c;
    mode_e mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            vclk_q <= 1'b1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            vclk_q <= vclk;
            scl_q  <= scl;
            sda_q  <= sda_in;
        end
    end

    assign vclk_rise = vclk & ~vclk_q;
    assign scl_fall  = scl_q & ~scl;
    assign scl_rise  = ~scl_q & scl;
    assign scl_edge  = scl_q ^ scl;
    assign start_c   = scl_q & scl & sda_q & ~sda_in;
    assign stop_c    = scl_q & scl & ~sda_q & sda_in;

    logic [AW-1:0]         ser_addr, slv_addr;
    logic [7:0]            ser_byte, slv_byte;
    logic                  ser_low, slv_low, ctrl_ok, cm_en;
    logic [AW-PW-1:0]      cm_page;
    logic [PB-1:0]         cm_mask;
    logic [PB-1:0][7:0]    cm_data;

    ddc_mode_arb #(.FALLBACK_PULSES(FALLBACK_PULSES)) u_arb (
        .clk(clk), .rst(rst), .scl_fall(scl_fall), .scl_edge(scl_edge),
        .vclk_rise(vclk_rise), .ctrl_ok(ctrl_ok), .mode(mode)
    );

    ddc_txo_ser #(.AW(AW)) u_ser (
        .clk(clk), .rst(rst), .active(mode == MODE_TXO), .vclk_rise(vclk_rise),
        .byte_in(ser_byte), .rd_addr(ser_addr), .sda_low(ser_low)
    );

    ddc_i2c_slave #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_slv (
        .clk(clk), .rst(rst), .en(mode != MODE_TXO), .sda(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
        .stop_c(stop_c), .wp(wp), .rd_data(slv_byte), .rd_addr(slv_addr),
        .sda_low(slv_low), .ctrl_ok(ctrl_ok), .cm_en(cm_en),
        .cm_page(cm_page), .cm_mask(cm_mask), .cm_data(cm_data)
    );

    ddc_id_mem #(.AW(AW), .PW(PW)) u_mem (
        .clk(clk), .rst(rst),
        .ra_addr(ser_addr), .ra_data(ser_byte),
        .rb_addr(slv_addr), .rb_data(slv_byte),
        .cm_en(cm_en), .cm_page(cm_page), .cm_mask(cm_mask), .cm_data(cm_data)
    );

    assign sda_oe = (mode == MODE_TXO) ? ser_low : slv_low;

    // R3
    txo_only_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_TXO && sda_oe) |-> slv_low);

endmodule

// File: tb/ddc_monid_tb.sv
module ddc_monid_tb;

    localparam int H  = 8;
    localparam int WR = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vclk = 1'b0, scl = 1'b1, sda = 1'b1, wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda & ~sda_oe;

    always #4 clk = ~clk;

    ddc_monid #(.WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst(rst), .vclk(vclk), .scl(scl), .sda_in(sda_bus),
        .wp(wp), .sda_oe(sda_oe)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    bit wp_arm_m = 1'b0;
    logic [7:0] model [256];
    logic [7:0] wbuf  [16];
    logic [7:0] rbuf  [16];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic vpulse();
        vclk = 1'b1; wt(4); vclk = 1'b0; wt(4);
    endtask

    task automatic wake();
        scl = 1'b0; wt(H); scl = 1'b1; wt(H);
    endtask

    task automatic i_start();
        sda = 1'b0; wt(H); scl = 1'b0; wt(H);
    endtask

    task automatic i_rstart();
        sda = 1'b1; wt(H); scl = 1'b1; wt(H); sda = 1'b0; wt(H); scl = 1'b0; wt(H);
    endtask

    task automatic i_stop();
        sda = 1'b0; wt(H); scl = 1'b1; wt(H); sda = 1'b1; wt(H);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
        end
        sda = 1'b1; wt(H); scl = 1'b1; wt(H/2);
        ack = !sda_bus;
        wt(H/2); scl = 1'b0;
    endtask

    task automatic rbyte(input bit last, output logic [7:0] b);
        sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl = 1'b1; wt(H/2); b[i] = sda_bus; wt(H/2); scl = 1'b0;
        end
        sda = last; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic i2c_write(input logic [7:0] a, input int n, output bit ok);
        bit k;
        ok = 1'b1;
        i_start();
        wbyte(8'hA0, k); ok &= k;
        wbyte(a, k);     ok &= k;
        for (int i = 0; i < n; i++) begin wbyte(wbuf[i], k); ok &= k; end
        i_stop();
    endtask

    task automatic i2c_read(input logic [7:0] a, input int n, output bit ok);
        bit k;
        ok = 1'b1;
        i_start();
        wbyte(8'hA0, k); ok &= k;
        wbyte(a, k);     ok &= k;
        i_rstart();
        wbyte(8'hA1, k); ok &= k;
        for (int i = 0; i < n; i++) rbyte(i == n - 1, rbuf[i]);
        i_stop();
    endtask

    function automatic void model_write(input logic [7:0] a, input int n, input bit blk);
        if (!blk) begin
            for (int i = 0; i < n; i++) begin
                logic [2:0] off;
                logic [7:0] ad;
                off = a[2:0] + 3'(i);
                ad  = {a[7:3], off};
                model[ad] = wbuf[i];
                if (ad == 8'h7F) wp_arm_m = 1'b1;
            end
        end
    endfunction

    function automatic logic exp_low(input int p);
        logic [7:0] b;
        b = model[(p >> 3) & 127];
        return ~b[7 - (p & 7)];
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        bit ok, k;
        void'($urandom(32'd7341));
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
        wt(4); rst = 1'b0; wt(2);

        // R1: reset state, stream parked at bit 7 of 00h
        chk("R1 reset sda_oe", sda_oe, exp_low(0));

        // R2: full stream across the 7Fh -> 00h wrap
        for (int p = 1; p <= 1040; p++) begin
            vpulse();
            chk("R2 stream bit", sda_oe, exp_low(p));
        end

        // R3: scl fall leaves streaming, line released
        wake();
        chk("R3 released", sda_oe, 0);
        for (int i = 0; i < 3; i++) begin
            vpulse();
            chk("R3 vclk ignored", sda_oe, 0);
        end

        // R5: scl edge clears count; 127 stays, 128th falls back
        scl = 1'b0; wt(H); scl = 1'b1; wt(H);
        for (int i = 0; i < 127; i++) vpulse();
        chk("R5 still transition at 127", sda_oe, 0);
        vpulse();
        chk("R5 fallback restart", sda_oe, exp_low(0));
        for (int p = 1; p < 8; p++) begin
            vpulse();
            chk("R5 restarted stream", sda_oe, exp_low(p));
        end

        // R4: wrong device code refused
        wake();
        i_start(); wbyte(8'hA2, k); i_stop();
        chk("R4 wrong id nack", k, 0);

        // R4 + R7: correct id acked, single byte write
        wbuf[0] = 8'h3C;
        i2c_write(8'h10, 1, ok);
        chk("R4 id ack", ok, 1);
        model_write(8'h10, 1, 1'b0);

        // R9: poll during modelled write time
        i_start(); wbyte(8'hA0, k); i_stop();
        chk("R9 busy nack", k, 0);
        wt(WR + 20);
        i_start(); wbyte(8'hA0, k); i_stop();
        chk("R9 ready ack", k, 1);

        i2c_read(8'h10, 1, ok);
        chk("R7 byte readback", rbuf[0], model[8'h10]);

        // R11: vclk in bidirectional mode
        for (int i = 0; i < 200; i++) vpulse();
        chk("R11 no drive", sda_oe, 0);
        i2c_read(8'h10, 1, ok);
        chk("R11 still slave", ok, 1);
        chk("R11 data intact", rbuf[0], model[8'h10]);

        // R8: ten bytes from 23h wrap inside page 20h..27h
        for (int i = 0; i < 10; i++) wbuf[i] = 8'hC0 + 8'(i);
        i2c_write(8'h23, 10, ok);
        model_write(8'h23, 10, 1'b0);
        wt(WR + 20);
        i2c_read(8'h20, 8, ok);
        for (int i = 0; i < 8; i++) chk("R8 page wrap", rbuf[i], model[8'h20 + i]);

        // R6: sequential read across FFh -> 00h
        i2c_read(8'hFE, 3, ok);
        chk("R6 seq FE", rbuf[0], model[8'hFE]);
        chk("R6 seq FF", rbuf[1], model[8'hFF]);
        chk("R6 seq 00", rbuf[2], model[8'h00]);

        // R10: write protect arming
        wp = 1'b1;
        wbuf[0] = 8'h11;
        i2c_write(8'h7E, 1, ok); model_write(8'h7E, 1, wp_arm_m && wp); wt(WR + 20);
        i2c_read(8'h7E, 1, ok);
        chk("R10 unarmed write", rbuf[0], model[8'h7E]);
        wbuf[0] = 8'h22;
        i2c_write(8'h7F, 1, ok); model_write(8'h7F, 1, wp_arm_m && wp); wt(WR + 20);
        i2c_read(8'h7F, 1, ok);
        chk("R10 arm write", rbuf[0], 8'h22);
        wbuf[0] = 8'h99;
        i2c_write(8'h30, 1, ok); model_write(8'h30, 1, wp_arm_m && wp); wt(WR + 20);
        i2c_read(8'h30, 1, ok);
        chk("R10 blocked", rbuf[0], 8'h30 ^ 8'h5A);
        wp = 1'b0;
        i2c_write(8'h30, 1, ok); model_write(8'h30, 1, wp_arm_m && wp); wt(WR + 20);
        i2c_read(8'h30, 1, ok);
        chk("R10 wp low", rbuf[0], 8'h99);

        // R7/R8/R10: constrained random page writes with page readback
        for (int it = 0; it < 12; it++) begin
            logic [7:0] a;
            int n;
            a  = 8'($urandom % 256);
            n  = 1 + int'($urandom % 10);
            wp = (($urandom % 4) == 0);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            i2c_write(a, n, ok);
            chk("R7 random write ack", ok, 1);
            model_write(a, n, wp_arm_m && wp);
            wp = 1'b0;
            wt(WR + 20);
            i2c_read({a[7:3], 3'b000}, 8, ok);
            for (int i = 0; i < 8; i++)
                chk("R7 random page", rbuf[i], model[{a[7:3], 3'(i)}]);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule